// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns a free-running reference clock into the oversampling strobe a UART transmitter and receiver run on. A 16-bit integer divisor and a 4-bit fraction in sixteenths set the average spacing of the strobe to div_int + div_frac/16 reference cycles. The fraction is realised by stretching selected periods by one cycle, so the strobe is irregular but exact on average. For example, a 28.23 MHz reference with div_int = 9 and div_frac = 5 gives close to 189.5 kbaud in standard mode.

A two-bit rate mode sets how many strobes make one bit time: 16, 8 or 4. The same divisor therefore gives a line rate of one, two or four times the base rate. A bit strobe marks the last sample of each bit time. A clock-disable input parks the generator so the divisor can be rewritten safely. Releasing it restarts the generator from a clean phase. An optional observation clock shows the strobe rate as a waveform that can be probed on a pin.

Top module: `frac_baud_gen`

## Requirements
- R1: While rst or clk_dis is high, sample_tick and bit_tick stay low, and obs_clk is low from the next cycle on.
- R2: With div_frac = 0, consecutive sample_tick pulses are exactly div_int reference cycles apart and each pulse lasts one cycle. div_int = 1 gives a pulse in every cycle.
- R3: After clk_dis falls, the first sample_tick comes in the div_int-th cycle, where the first cycle with clk_dis low counts as cycle 1.
- R4: Every sample period lasts div_int or div_int + 1 cycles. The first 16 periods after a restart together last 16*div_int + div_frac cycles.
- R5: Period k after a restart (k = 0, 1, ...) lasts div_int + floor((k+1)*div_frac/16) - floor(k*div_frac/16) cycles.
- R6: rate_mode selects the samples per bit: 2'b00 gives 16, 2'b01 gives 8, 2'b10 gives 4, and 2'b11 behaves as 2'b00. bit_tick is high only together with sample_tick, on every Nth sample_tick counted from the restart.
- R7: Raising clk_dis for a single cycle in the middle of a period discards both the fractional phase and the sample count. A divisor written during that cycle then takes effect with the timing of R3, and the bit count starts again from zero.
- R8: With obs_en high and the generator running, obs_clk is high in cycle c+1 exactly when cycle c lies within the first max(1, floor(div_int/2)) cycles of a sample period. With obs_en low, obs_clk is low one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_dis | input | 1 | Parks the generator and clears its phase while high |
| div_int | input | 16 | Integer divisor; low byte nonzero |
| div_frac | input | 4 | Fractional divisor in sixteenths |
| rate_mode | input | 2 | Samples per bit: 00 = 16, 01 = 8, 10 = 4, 11 = 16 |
| obs_en | input | 1 | Enables the observation clock |
| sample_tick | output | 1 | One-cycle oversampling strobe |
| bit_tick | output | 1 | Strobe on the last sample of each bit time |
| obs_clk | output | 1 | Registered observation clock at the sample rate |

## Verification
The assertions assume that the low byte of div_int is nonzero. They also assume that div_int, div_frac and rate_mode change only in cycles where clk_dis or rst is high, since a divisor rewritten during a live period has no defined period length. The stimulus follows these rules throughout. Every divisor and mode change is made together with a raised clk_dis, and every programmed integer divisor has a nonzero low byte. This includes the smallest divisor of one and a divisor of 300 with the largest fraction.

// File: rtl/fbrg_pkg.sv
package fbrg_pkg;

    typedef enum logic [1:0] {
        RM_X16 = 2'b00,
        RM_X8  = 2'b01,
        RM_X4  = 2'b10,
        RM_RSV = 2'b11
    } rate_mode_e;

    localparam int OSR_MAX = 16;
    localparam int OS_W    = $clog2(OSR_MAX);

    typedef struct packed {
        logic sample;
        logic bit_end;
    } tick_pair_t;

    function automatic logic [OS_W:0] osr_of(input rate_mode_e m);
        case (m)
            RM_X8:   return (OS_W+1)'(8);
            RM_X4:   return (OS_W+1)'(4);
            default: return (OS_W+1)'(16);
        endcase
    endfunction

endpackage

// File: rtl/fbrg_phase.sv
module fbrg_phase
    import fbrg_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 4,
    localparam int CNT_W = DIV_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [DIV_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    output logic              tick,
    output logic [CNT_W-1:0]  cnt
);
    logic [FRAC_W-1:0] acc;
    logic [FRAC_W:0]   acc_sum;
    logic              stretch;
    logic [CNT_W-1:0]  lim;
    logic              hit;

    always_comb begin
        acc_sum = {1'b0, acc} + {1'b0, div_frac};
        stretch = acc_sum[FRAC_W];
        lim     = CNT_W'(div_int) + CNT_W'(stretch) - CNT_W'(1);
        hit     = (cnt == lim);
        tick    = run & hit;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            acc <= '0;
        end else if (hit) begin
            cnt <= '0;
            acc <= acc_sum[FRAC_W-1:0];
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/fbrg_oscnt.sv
module fbrg_oscnt
    import fbrg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       sample_tick,
    input  rate_mode_e mode,
    output logic       bit_tick
);
    logic [OS_W-1:0] os;
    logic [OS_W:0]   osr;
    logic [OS_W-1:0] last;

    always_comb begin
        osr      = osr_of(mode);
        last     = OS_W'(osr - (OS_W+1)'(1));
        bit_tick = sample_tick & (os == last);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            os <= '0;
        end else if (sample_tick) begin
            os <= (os == last) ? '0 : os + OS_W'(1);
        end
    end
endmodule

// File: rtl/fbrg_obs.sv
module fbrg_obs #(
    parameter int DIV_W  = 16,
    localparam int CNT_W = DIV_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             obs_en,
    input  logic [DIV_W-1:0] div_int,
    input  logic [CNT_W-1:0] cnt,
    output logic             obs_clk
);
    logic [CNT_W-1:0] hi_len;

    always_comb begin
        hi_len = CNT_W'(div_int >> 1);
        if (hi_len == '0) hi_len = CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) obs_clk <= 1'b0;
        else     obs_clk <= run & obs_en & (cnt < hi_len);
    end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import fbrg_pkg::*;
#(
    parameter int DIV_W   = 16,
    parameter int FRAC_W  = 4,
    parameter bit HAS_OBS = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_dis,
    input  logic [DIV_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    input  logic [1:0]        rate_mode,
    input  logic              obs_en,
    output logic              sample_tick,
    output logic              bit_tick,
    output logic              obs_clk
);
    localparam int CNT_W = DIV_W + 1;

    logic             run;
    logic [CNT_W-1:0] cnt;
    tick_pair_t       ticks;
    rate_mode_e       mode;

    assign run  = ~rst & ~clk_dis;
    assign mode = rate_mode_e'(rate_mode);

    fbrg_phase #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_phase (
        .clk(clk), .rst(rst), .run(run),
        .div_int(div_int), .div_frac(div_frac),
        .tick(ticks.sample), .cnt(cnt)
    );

    fbrg_oscnt u_oscnt (
        .clk(clk), .rst(rst), .run(run),
        .sample_tick(ticks.sample), .mode(mode),
        .bit_tick(ticks.bit_end)
    );

    generate
        if (HAS_OBS) begin : g_obs
            fbrg_obs #(.DIV_W(DIV_W)) u_obs (
                .clk(clk), .rst(rst), .run(run), .obs_en(obs_en),
                .div_int(div_int), .cnt(cnt), .obs_clk(obs_clk)
            );
        end else begin : g_no_obs
            assign obs_clk = 1'b0;
        end
    endgenerate

    assign sample_tick = ticks.sample;
    assign bit_tick    = ticks.bit_end;
endmodule

// File: rtl/fbrg_chk.sv
module fbrg_chk
    import fbrg_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              clk_dis,
    input logic [DIV_W-1:0]  div_int,
    input logic [FRAC_W-1:0] div_frac,
    input logic [1:0]        rate_mode,
    input logic              obs_en,
    input logic              sample_tick,
    input logic              bit_tick,
    input logic              obs_clk
);
    localparam int GW = DIV_W + 2;

    logic [GW-1:0]   gap;
    logic [GW-1:0]   gap_len;
    logic [GW-1:0]   div_x;
    logic            seen;
    logic [OS_W:0]   tsince;
    logic [OS_W:0]   osr;

    assign gap_len = gap + GW'(1);
    assign div_x   = GW'(div_int);
    assign osr     = osr_of(rate_mode_e'(rate_mode));

    always_ff @(posedge clk) begin
        if (rst || clk_dis) begin
            gap    <= '0;
            seen   <= 1'b0;
            tsince <= '0;
        end else if (sample_tick) begin
            gap    <= '0;
            seen   <= 1'b1;
            tsince <= bit_tick ? '0 : tsince + (OS_W+1)'(1);
        end else begin
            gap <= gap + GW'(1);
        end
    end

    AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        clk_dis |-> (!sample_tick && !bit_tick)); // R1

    AST_OBS_QUIET: assert property (@(posedge clk) disable iff (rst)
        (clk_dis || !obs_en) |=> !obs_clk); // R8

    AST_INT_PERIOD: assert property (@(posedge clk) disable iff (rst)
        (sample_tick && seen && div_frac == '0) |-> gap_len == div_x); // R2

    AST_FIRST_TICK: assert property (@(posedge clk) disable iff (rst)
        (sample_tick && !seen) |-> gap_len == div_x); // R3

    AST_PERIOD_BOUND: assert property (@(posedge clk) disable iff (rst)
        (sample_tick && seen) |-> (gap_len == div_x || gap_len == div_x + GW'(1))); // R4

    AST_BIT_WITH_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> sample_tick); // R6

    AST_BIT_SPACING: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> (tsince + (OS_W+1)'(1)) == osr); // R6
endmodule

bind frac_baud_gen fbrg_chk #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_chk (
    .clk(clk), .rst(rst), .clk_dis(clk_dis), .div_int(div_int),
    .div_frac(div_frac), .rate_mode(rate_mode), .obs_en(obs_en),
    .sample_tick(sample_tick), .bit_tick(bit_tick), .obs_clk(obs_clk)
);

// File: tb/frac_baud_gen_tb_top.sv
`timescale 1ns/1ps
module frac_baud_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clk_dis = 1'b0;
    logic [15:0] div_int = 16'd1;
    logic [3:0]  div_frac = 4'd0;
    logic [1:0]  rate_mode = 2'b00;
    logic        obs_en = 1'b1;
    logic        sample_tick, bit_tick, obs_clk;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    frac_baud_gen dut_i (
        .clk(clk), .rst(rst), .clk_dis(clk_dis), .div_int(div_int),
        .div_frac(div_frac), .rate_mode(rate_mode), .obs_en(obs_en),
        .sample_tick(sample_tick), .bit_tick(bit_tick), .obs_clk(obs_clk)
    );

    // fields: div_int[27:12], div_frac[11:8], rate_mode[7:6], expected samples per bit[5:0]
    localparam int N_VEC = 7;
    localparam logic [27:0] VEC [N_VEC] = '{
        {16'd9,   4'd5,  2'b00, 6'd16},
        {16'd1,   4'd0,  2'b01, 6'd8},
        {16'd1,   4'd8,  2'b10, 6'd4},
        {16'd4,   4'd0,  2'b11, 6'd16},
        {16'd6,   4'd15, 2'b01, 6'd8},
        {16'd300, 4'd15, 2'b10, 6'd4},
        {16'd2,   4'd1,  2'b00, 6'd16}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_per(input int d, input int f, input int k);
        return d + (((k + 1) * f) >> 4) - ((k * f) >> 4);
    endfunction

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    // park, program, release; returns with sample point t=1 taken
    task automatic restart(input int d, input int f, input logic [1:0] m, input logic oe);
        @(negedge clk);
        clk_dis = 1'b1; div_int = 16'(d); div_frac = 4'(f); rate_mode = m; obs_en = oe;
        @(negedge clk);
        @(negedge clk);
        clk_dis = 1'b0;
        #1;
    endtask

    task automatic run_vec(input int idx);
        int d, f, osr, t, prev_t, k, ntick, nbit, rises, hi, exp_rises;
        logic prev_obs;
        d   = int'(VEC[idx][27:12]);
        f   = int'(VEC[idx][11:8]);
        osr = int'(VEC[idx][5:0]);
        restart(d, f, VEC[idx][7:6], 1'b1);
        t = 1; prev_t = 0; k = 0; ntick = 0; nbit = 0; rises = 0; prev_obs = 1'b0;
        hi = ((d >> 1) == 0) ? 1 : (d >> 1);
        exp_rises = 1;
        for (int j = 0; j < 15; j++) if (exp_per(d, f, j) > hi) exp_rises++;
        while (ntick < 16) begin
            if (obs_clk && !prev_obs) rises++;
            prev_obs = obs_clk;
            if (bit_tick) begin
                nbit++;
                chk(sample_tick && ((ntick + 1) % osr == 0), "R6", "bit_tick position (sample index)",
                    ntick + 1, osr * nbit);
            end
            if (sample_tick) begin
                ntick++;
                if (k == 0) chk(t - prev_t == d, "R3", "first tick cycle", t - prev_t, d);
                else if (f == 0) chk(t - prev_t == d, "R2", "integer period", t - prev_t, d);
                else chk(t - prev_t == exp_per(d, f, k), "R5", "fractional period",
                         t - prev_t, exp_per(d, f, k));
                prev_t = t;
                k++;
            end
            if (ntick < 16) begin
                if (t > 16 * (d + 1) + 8) begin
                    chk(1'b0, "R4", "ticks missing, count", ntick, 16);
                    break;
                end
                @(negedge clk);
                #1;
                t++;
            end
        end
        chk(prev_t == 16 * d + f, "R4", "16-period span", prev_t, 16 * d + f);
        chk(nbit == 16 / osr, "R6", "bit_tick count", nbit, 16 / osr);
        chk(rises == exp_rises, "R8", "obs_clk rising edges", rises, exp_rises);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int cnt_t, cnt_o, first_t, first_b, nb;
        // R1: reset holds outputs low even with a divisor that would tick every cycle
        repeat (3) @(negedge clk);
        #1;
        chk(!sample_tick, "R1", "sample_tick in reset", sample_tick, 0);
        chk(!bit_tick, "R1", "bit_tick in reset", bit_tick, 0);
        chk(!obs_clk, "R1", "obs_clk in reset", obs_clk, 0);
        @(negedge clk);
        clk_dis = 1'b1;
        rst = 1'b0;

        // R1: clock disable holds everything quiet
        cnt_t = 0; cnt_o = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            #1;
            if (sample_tick || bit_tick) cnt_t++;
            if (obs_clk) cnt_o++;
        end
        chk(cnt_t == 0, "R1", "ticks while disabled", cnt_t, 0);
        chk(cnt_o == 0, "R1", "obs_clk high while disabled", cnt_o, 0);

        // table of divisor / mode vectors (R2..R6, R8)
        for (int i = 0; i < N_VEC; i++) run_vec(i);

        // R8: observation clock off while ticks continue
        restart(3, 0, 2'b00, 1'b0);
        cnt_t = 0; cnt_o = 0;
        for (int i = 1; i <= 60; i++) begin
            if (sample_tick) cnt_t++;
            if (obs_clk) cnt_o++;
            @(negedge clk);
            #1;
        end
        chk(cnt_o == 0, "R8", "obs_clk high with obs_en low", cnt_o, 0);
        chk(cnt_t == 20, "R2", "ticks in 60 cycles at div 3", cnt_t, 20);

        // R7: restart mid-period with a new divisor
        restart(5, 3, 2'b10, 1'b1);
        for (int i = 1; i < 13; i++) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        clk_dis = 1'b1; div_int = 16'd7; div_frac = 4'd0; rate_mode = 2'b10;
        #1;
        chk(!sample_tick, "R7", "tick during one-cycle disable", sample_tick, 0);
        @(negedge clk);
        clk_dis = 1'b0;
        #1;
        first_t = 0; first_b = 0; nb = 0;
        for (int t = 1; t <= 28; t++) begin
            if (sample_tick && first_t == 0) first_t = t;
            if (bit_tick) begin
                nb++;
                if (first_b == 0) first_b = t;
            end
            if (t < 28) begin
                @(negedge clk);
                #1;
            end
        end
        chk(first_t == 7, "R7", "first tick after restart", first_t, 7);
        chk(first_b == 28, "R7", "first bit_tick after restart", first_b, 28);
        chk(nb == 1, "R7", "bit_tick count in 28 cycles", nb, 1);

        summary();
        $finish;
    end
endmodule